// File: doc/BRIEF.md
# Network Reconfiguration Sequencer

This block steps a packet network through an ordered series of configurations. A small table holds one row per transition. Each row has three fields: the cycle at which the network inputs close, the length of the drain window, and the number of cycles that loading the next configuration takes. A pulse on the go input starts the sequence at cycle 0 with configuration 0 live. The sequencer then handles each transition in order. It closes the inputs, lets packets in flight leave during the drain window, and at the end of that window discards whatever is still inside. It then holds a load strobe for the load duration, and finally reopens the inputs with the configuration index advanced by one.

A free-running cycle counter gives the time base that the stop times are compared against. A network-empty status input only gates the discard strobe. The drain window always runs its full length, even when the network empties early. The table can only be written while the sequencer is idle or has finished its list.

Top module: `recfg_sequencer`

## Requirements
- R1: After reset the inputs are closed (`in_en` 0), `flush`, `load_strobe`, `cfg_idx` and `cycle` are all 0, and the table accepts writes.
- R2: A `seq_go` pulse accepted while idle or finished makes `cycle` read 0 in the next cycle, with `cfg_idx` 0 and `in_en` 1. From then on `cycle` rises by one every cycle.
- R3: `cfg_we` stores stop time, drain length and load length into table row `cfg_addr` only while idle or finished. Writes and `seq_go` pulses that arrive during a running sequence change nothing.
- R4: For the pending row, `in_en` falls in the cycle where `cycle` equals its stop time. If that time is not later than the cycle in which the current configuration went live, `in_en` falls one cycle after that cycle instead.
- R5: The drain window lasts for drain-length cycles, starting in the stop cycle, with `in_en` low throughout. A drain length of 0 counts as 1.
- R6: The discard cycle is the last cycle of the drain window. `flush` is high in that cycle exactly when `net_empty` is low, and it is never high in any other cycle. `net_empty` has no effect on any timing.
- R7: `load_strobe` is high for exactly load-length cycles, starting right after the discard cycle. A load length of 0 gives no load cycles.
- R8: In the cycle after the last load cycle (or after the discard cycle when the load length is 0), `in_en` returns to 1 and `cfg_idx` rises by exactly one.
- R9: Rows are used strictly in order 0, 1, ... up to the requested count, which is clipped to the table depth. After the last row, `in_en` stays 1 and `cfg_idx` equals that count.
- R10: `in_en` is never high in the same cycle as `load_strobe` or `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | IDX_W | Table row to write |
| cfg_stop | input | TIME_W | Cycle at which inputs close |
| cfg_drain | input | DUR_W | Drain window length in cycles |
| cfg_load | input | DUR_W | Load duration in cycles |
| seq_go | input | 1 | Start the sequence at cycle 0 |
| seq_len | input | CNT_W | Number of transitions to perform |
| net_empty | input | 1 | Network holds no packets |
| in_en | output | 1 | Network inputs may accept packets |
| flush | output | 1 | Discard packets still in the network |
| load_strobe | output | 1 | New configuration is being loaded |
| cfg_idx | output | CNT_W | Index of the live configuration |
| cycle | output | TIME_W | Cycles since the sequence started |

## Verification
Several properties are checked on every cycle. The inputs are never open during a load or a discard. The discard strobe never lasts more than one cycle, and a load phase is only ever entered from the discard cycle. Each return to running raises the configuration index by exactly one. The inputs never close before the row's stop time, and table rows stay frozen while a sequence runs.

Other properties only the bench scenarios can show: that each window has exactly the programmed length, how stop times already in the past are handled, zero drain and zero load lengths, clipping of the transition count, and that writes made in mid-sequence are ignored. For these the bench compares every output cycle by cycle against a timeline it computes from the table, while driving `net_empty` randomly.

// File: rtl/recfg_pkg.sv
`timescale 1ns/1ps
package recfg_pkg;

   // Sequencer phases; IDLE precedes the first go, DONE follows the last row
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_DRAIN = 3'd2,
      ST_FLUSH = 3'd3,
      ST_LOAD  = 3'd4,
      ST_DONE  = 3'd5
   } recfg_state_e;

   function automatic logic table_open(input recfg_state_e s);
      return (s == ST_IDLE) || (s == ST_DONE);
   endfunction

endpackage

// File: rtl/recfg_cycle_ctr.sv
`timescale 1ns/1ps
module recfg_cycle_ctr #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   output logic [TIME_W-1:0] count
);

   localparam logic [TIME_W-1:0] CNT_MAX = '1;

   // saturating time base; cleared by an accepted start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (en && (count != CNT_MAX)) begin
         count <= count + TIME_W'(1);
      end
   end

endmodule

// File: rtl/recfg_table.sv
`timescale 1ns/1ps
module recfg_table #(
   parameter int MAX_ENTRIES = 8,
   parameter int TIME_W      = 16,
   parameter int DUR_W       = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W = $clog2(MAX_ENTRIES),
   localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [TIME_W-1:0] wstop,
   input  logic [DUR_W-1:0]  wdrain,
   input  logic [DUR_W-1:0]  wload,
   input  logic [CNT_W-1:0]  raddr,
   output logic [TIME_W-1:0] rstop,
   output logic [DUR_W-1:0]  rdrain,
   output logic [DUR_W-1:0]  rload
);

   logic [TIME_W-1:0] stop_q  [MAX_ENTRIES];
   logic [DUR_W-1:0]  drain_q [MAX_ENTRIES];
   logic [DUR_W-1:0]  load_q  [MAX_ENTRIES];

   for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_row
      logic hit;
      assign hit = wr_ok && we && (waddr == IDX_W'(i));

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stop_q[i]  <= '0;
               drain_q[i] <= '0;
               load_q[i]  <= '0;
            end else if (hit) begin
               stop_q[i]  <= wstop;
               drain_q[i] <= wdrain;
               load_q[i]  <= wload;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) begin
               stop_q[i]  <= wstop;
               drain_q[i] <= wdrain;
               load_q[i]  <= wload;
            end
         end
      end

      // R3
      row_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_ok |=> ($stable(stop_q[i]) && $stable(drain_q[i]) && $stable(load_q[i])));
   end

   logic in_range;
   assign in_range = (raddr < CNT_W'(MAX_ENTRIES));

   always_comb begin
      rstop  = '0;
      rdrain = '0;
      rload  = '0;
      if (in_range) begin
         rstop  = stop_q[raddr[IDX_W-1:0]];
         rdrain = drain_q[raddr[IDX_W-1:0]];
         rload  = load_q[raddr[IDX_W-1:0]];
      end
   end

endmodule

// File: rtl/recfg_fsm.sv
`timescale 1ns/1ps
module recfg_fsm
   import recfg_pkg::*;
#(
   parameter int MAX_ENTRIES = 8,
   parameter int TIME_W      = 16,
   parameter int DUR_W       = 8,
   localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CNT_W-1:0]  len_in,
   input  logic [TIME_W-1:0] cyc,
   input  logic [TIME_W-1:0] e_stop,
   input  logic [DUR_W-1:0]  e_drain,
   input  logic [DUR_W-1:0]  e_load,
   output recfg_state_e      st,
   output logic [CNT_W-1:0]  tr
);

   localparam logic [CNT_W-1:0] DEPTH = CNT_W'(MAX_ENTRIES);

   logic [CNT_W-1:0]  len_q;
   logic [DUR_W-1:0]  win;
   logic [TIME_W:0]   cyc_nx;
   logic              stop_due;
   logic [CNT_W-1:0]  len_clip;

   assign cyc_nx   = {1'b0, cyc} + (TIME_W+1)'(1);
   assign stop_due = (cyc_nx >= {1'b0, e_stop});
   assign len_clip = (len_in > DEPTH) ? DEPTH : len_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tr    <= '0;
         len_q <= '0;
         win   <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE: begin
               if (go) begin
                  st    <= ST_RUN;
                  tr    <= '0;
                  len_q <= len_clip;
               end
            end
            ST_RUN: begin
               if (tr >= len_q) begin
                  st <= ST_DONE;
               end else if (stop_due) begin
                  if (e_drain <= DUR_W'(1)) begin
                     st <= ST_FLUSH;
                  end else begin
                     st  <= ST_DRAIN;
                     win <= e_drain - DUR_W'(2);
                  end
               end
            end
            ST_DRAIN: begin
               if (win == '0) st <= ST_FLUSH;
               else           win <= win - DUR_W'(1);
            end
            ST_FLUSH: begin
               if (e_load == '0) begin
                  st <= ST_RUN;
                  tr <= tr + CNT_W'(1);
               end else begin
                  st  <= ST_LOAD;
                  win <= e_load - DUR_W'(1);
               end
            end
            ST_LOAD: begin
               if (win == '0) begin
                  st <= ST_RUN;
                  tr <= tr + CNT_W'(1);
               end else begin
                  win <= win - DUR_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R6
   flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLUSH) |=> (st != ST_FLUSH));

   // R7
   load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_LOAD) |-> $past(st == ST_FLUSH));

   // R8
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RUN) && ($past(st) == ST_FLUSH || $past(st) == ST_LOAD))
      |-> (tr == $past(tr) + CNT_W'(1)));

   // R9
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |-> (tr <= len_q && len_q <= DEPTH));

endmodule

// File: rtl/recfg_sequencer.sv
`timescale 1ns/1ps
module recfg_sequencer
   import recfg_pkg::*;
#(
   parameter int MAX_ENTRIES = 8,
   parameter int TIME_W      = 16,
   parameter int DUR_W       = 8,
   parameter bit CLEAR_TABLE_ON_RESET = 1'b1,
   localparam int IDX_W = $clog2(MAX_ENTRIES),
   localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_addr,
   input  logic [TIME_W-1:0] cfg_stop,
   input  logic [DUR_W-1:0]  cfg_drain,
   input  logic [DUR_W-1:0]  cfg_load,
   input  logic              seq_go,
   input  logic [CNT_W-1:0]  seq_len,
   input  logic              net_empty,
   output logic              in_en,
   output logic              flush,
   output logic              load_strobe,
   output logic [CNT_W-1:0]  cfg_idx,
   output logic [TIME_W-1:0] cycle
);

   if (MAX_ENTRIES < 2) begin : g_bad_depth
      $error("recfg_sequencer: MAX_ENTRIES must be at least 2");
   end
   if (TIME_W < 2) begin : g_bad_time
      $error("recfg_sequencer: TIME_W must be at least 2");
   end
   if (DUR_W < 2) begin : g_bad_dur
      $error("recfg_sequencer: DUR_W must be at least 2");
   end

   recfg_state_e      st;
   logic [CNT_W-1:0]  tr;
   logic [TIME_W-1:0] e_stop;
   logic [DUR_W-1:0]  e_drain;
   logic [DUR_W-1:0]  e_load;
   logic              open_q;
   logic              go_ok;

   assign open_q = table_open(st);
   assign go_ok  = open_q && seq_go;

   recfg_table #(
      .MAX_ENTRIES   (MAX_ENTRIES),
      .TIME_W        (TIME_W),
      .DUR_W         (DUR_W),
      .CLEAR_ON_RESET(CLEAR_TABLE_ON_RESET)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ok (open_q),
      .we    (cfg_we),
      .waddr (cfg_addr),
      .wstop (cfg_stop),
      .wdrain(cfg_drain),
      .wload (cfg_load),
      .raddr (tr),
      .rstop (e_stop),
      .rdrain(e_drain),
      .rload (e_load)
   );

   recfg_cycle_ctr #(
      .TIME_W(TIME_W)
   ) u_clock (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (go_ok),
      .en   (st != ST_IDLE),
      .count(cycle)
   );

   recfg_fsm #(
      .MAX_ENTRIES(MAX_ENTRIES),
      .TIME_W     (TIME_W),
      .DUR_W      (DUR_W)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go_ok),
      .len_in (seq_len),
      .cyc    (cycle),
      .e_stop (e_stop),
      .e_drain(e_drain),
      .e_load (e_load),
      .st     (st),
      .tr     (tr)
   );

   assign in_en       = (st == ST_RUN) || (st == ST_DONE);
   assign flush       = (st == ST_FLUSH) && !net_empty;
   assign load_strobe = (st == ST_LOAD);
   assign cfg_idx     = tr;

   // R10
   no_open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_en && (load_strobe || flush)));

   // R2
   start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_ok |=> (cycle == '0 && cfg_idx == '0 && in_en));

   // R4
   stop_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_en) |-> (cycle >= e_stop));

endmodule

// File: tb/tb_recfg_sequencer.sv
`timescale 1ns/1ps
module tb_recfg_sequencer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [15:0] cfg_stop = '0;
   logic [7:0] cfg_drain = '0;
   logic [7:0] cfg_load = '0;
   logic       seq_go = 1'b0;
   logic [3:0] seq_len = '0;
   logic       net_empty = 1'b1;
   logic       in_en, flush, load_strobe;
   logic [3:0] cfg_idx;
   logic [15:0] cycle;

   int checks = 0;
   int errors = 0;
   int m_stop [8];
   int m_drain[8];
   int m_load [8];

   always #2.5 clk = ~clk;

   recfg_sequencer dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_stop(cfg_stop), .cfg_drain(cfg_drain), .cfg_load(cfg_load),
      .seq_go(seq_go), .seq_len(seq_len), .net_empty(net_empty),
      .in_en(in_en), .flush(flush), .load_strobe(load_strobe),
      .cfg_idx(cfg_idx), .cycle(cycle)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called just after a falling edge; write lands on the next rising edge
   task automatic wr(input int a, input int s, input int d, input int l);
      cfg_we = 1'b1; cfg_addr = 3'(a);
      cfg_stop = 16'(s); cfg_drain = 8'(d); cfg_load = 8'(l);
      @(negedge clk);
      cfg_we = 1'b0;
      m_stop[a] = s; m_drain[a] = d; m_load[a] = l;
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // runs one sequence and compares every cycle against a computed timeline
   task automatic run_seq(input int len, input string stag, input int poke_at);
      int n, s, last;
      int t_st[8], t_fl[8], t_re[8];
      bit poked;
      n = (len > 8) ? 8 : len;
      s = 0;
      for (int k = 0; k < n; k++) begin
         t_st[k] = (m_stop[k] > s) ? m_stop[k] : s + 1;
         t_fl[k] = t_st[k] + imax(m_drain[k], 1) - 1;
         t_re[k] = t_fl[k] + 1 + m_load[k];
         s = t_re[k];
      end
      last = s + 4;
      poked = 1'b0;
      seq_go = 1'b1; seq_len = 4'(len);
      @(negedge clk);
      seq_go = 1'b0;
      for (int c = 0; c <= last; c++) begin
         int e_in, e_fl, e_ld, e_ix;
         bit in_drain;
         e_in = 1; e_fl = 0; e_ld = 0; e_ix = 0; in_drain = 1'b0;
         for (int k = 0; k < n; k++) begin
            if (c >= t_re[k]) e_ix = k + 1;
            if (c >= t_st[k] && c <= t_fl[k]) begin
               e_in = 0; in_drain = 1'b1;
               if (c == t_fl[k]) e_fl = net_empty ? 0 : 1;
            end
            if (c > t_fl[k] && c < t_re[k]) begin
               e_in = 0; e_ld = 1;
            end
         end
         chk({"R2 cycle ", stag}, int'(cycle), c);
         chk({in_drain ? "R5 in_en " : "R4 in_en ", stag}, int'(in_en), e_in);
         chk({"R6 flush ", stag}, int'(flush), e_fl);
         chk({"R7 load_strobe ", stag}, int'(load_strobe), e_ld);
         chk({"R8 cfg_idx ", stag}, int'(cfg_idx), e_ix);
         chk({"R10 overlap ", stag}, int'(in_en && (load_strobe || flush)), 0);
         if (poked) begin
            cfg_we = 1'b0; seq_go = 1'b0; poked = 1'b0;
         end
         if (c == poke_at) begin
            // mid-sequence write and restart attempt, both to be ignored
            cfg_we = 1'b1; cfg_addr = 3'd1; cfg_stop = 16'd5;
            cfg_drain = 8'd1; cfg_load = 8'd1;
            seq_go = 1'b1; seq_len = 4'd1;
            poked = 1'b1;
         end
         net_empty = 1'($urandom_range(0, 1));
         @(negedge clk);
      end
      cfg_we = 1'b0; seq_go = 1'b0;
      chk({"R9 final in_en ", stag}, int'(in_en), 1);
      chk({"R9 final cfg_idx ", stag}, int'(cfg_idx), n);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D2E3F4A));
      for (int i = 0; i < 8; i++) begin
         m_stop[i] = 0; m_drain[i] = 0; m_load[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 in_en", int'(in_en), 0);
      chk("R1 flush", int'(flush), 0);
      chk("R1 load_strobe", int'(load_strobe), 0);
      chk("R1 cfg_idx", int'(cfg_idx), 0);
      chk("R1 cycle", int'(cycle), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle in_en", int'(in_en), 0);
      chk("R1 idle cycle", int'(cycle), 0);

      // directed timeline: stop 30, load 40..49, live 50; stop 80, load 90..99, live 100
      wr(0, 30, 10, 10);
      wr(1, 80, 10, 10);
      run_seq(2, "directed", -1);

      // corner rows: zero drain and load, stop already past, drain of one
      wr(0, 5, 0, 0);
      wr(1, 0, 1, 3);
      wr(2, 20, 2, 0);
      run_seq(3, "corners", -1);

      // R9 empty list goes straight to the final state
      run_seq(0, "R9 empty", -1);

      // R3 writes and go during a running sequence are ignored
      wr(0, 12, 4, 4);
      wr(1, 30, 3, 2);
      run_seq(2, "R3 busy write", 2);
      run_seq(2, "R3 table kept", -1);

      // R9 count above depth is clipped
      for (int i = 0; i < 8; i++) wr(i, 10 * (i + 1) + 5, 2, 1);
      run_seq(12, "R9 clip", -1);

      // random tables, including stops already passed
      for (int r = 0; r < 8; r++) begin
         int t;
         t = 0;
         for (int i = 0; i < 8; i++) begin
            t = t + $urandom_range(0, 40);
            wr(i, ($urandom_range(0, 5) == 0) ? 0 : t,
               $urandom_range(0, 12), $urandom_range(0, 12));
         end
         run_seq($urandom_range(1, 8), "R6 random", -1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule